// File: doc/BRIEF.md
# Byte ALU with Status Flags

This block is the arithmetic and logic unit of an 8-bit datapath. It takes two operands and an operation code. From these it forms a result and a write-enable, both combinationally. The write-enable tells the surrounding pipeline whether the destination register should take the result.

Six status flags sit in a register: zero, carry, sign, overflow, parity and nibble (auxiliary) carry. The flag register loads only on a clock edge where `issue` is high. Its contents therefore always describe the last operation that was issued.

The supported operations are:
- the bitwise operations AND, OR, XOR and NOT;
- addition and subtraction;
- compare, which subtracts without writing back;
- test, which ANDs without writing back;
- single-bit test, which copies one bit of the first operand into the carry flag.

Top module: `byte_alu`

## Requirements
- R1: While `rstN` is low the flag register clears, so all six flag outputs read 0 after reset.
- R2: opCode 0 (AND), 1 (OR) and 2 (XOR) drive `result` with the bitwise function of `srcA` and `srcB` and assert `writeEn`. When issued, they clear carry, overflow and nibble carry.
- R3: opCode 4 (ADD) drives `result` with `srcA + srcB` modulo 256 and asserts `writeEn`. When issued, it sets the flags as follows:
  - carry: the unsigned carry out of bit 7;
  - nibble carry: the carry out of bit 3;
  - overflow: the carry into bit 7 XOR the carry out of bit 7.
- R4: opCode 5 (SUB) drives `result` with `srcA - srcB` modulo 256 and asserts `writeEn`. When issued, it sets the flags as follows:
  - carry: a borrow, set exactly when unsigned `srcA < srcB`;
  - nibble carry: set when the low nibble of `srcA` is below that of `srcB`;
  - overflow: set when the signed difference does not fit in 8 bits.
- R5: On every issued opcode from 0 to 7 except NOT, three flags are taken from the 8-bit result:
  - zero is set exactly when the result is 0;
  - sign copies result bit 7;
  - parity is set when the result holds an even number of 1 bits.
- R6: opCode 6 (CMP) sets all six flags exactly as SUB would and deasserts `writeEn`. For unsigned operands this gives: `srcA < srcB` yields carry=1 and zero=0, equal operands yield zero=1 and carry=0, and `srcA > srcB` clears both.
- R7: opCode 7 (TEST) sets the flags exactly as AND would and deasserts `writeEn`.
- R8: opCode 8 (bit test) loads carry with bit (`srcB` mod 8) of `srcA`, leaves the other five flags unchanged and deasserts `writeEn`. `result` shows `srcA`.
- R9: opCode 3 (NOT) drives `result` with `~srcA`, asserts `writeEn` and leaves all six flags unchanged.
- R10: On a clock edge with `issue` low the flags keep their value, whatever the opcode and operands.
- R11: opCodes 9 to 15 drive `result` to 0, deassert `writeEn` and leave the flags unchanged even when issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset of the flag register |
| issue | input | 1 | Loads the flags of the current operation at the next edge |
| opCode | input | 4 | Operation select |
| srcA | input | 8 | Destination operand |
| srcB | input | 8 | Source operand, or the bit index for bit test |
| result | output | 8 | Combinational operation result |
| writeEn | output | 1 | High when the destination should take `result` |
| flagZero | output | 1 | Registered zero flag |
| flagCarry | output | 1 | Registered carry / borrow flag |
| flagSign | output | 1 | Registered sign flag |
| flagOvf | output | 1 | Registered signed overflow flag |
| flagParity | output | 1 | Registered even-parity flag |
| flagAux | output | 1 | Registered nibble carry flag |

## Verification
The flag register is the only internal state. A wrong value captured there shows up at the flag outputs one clock after the issuing edge. A flag field that should have been held but was overwritten shows up at the same moment, as a change after a NOT, a bit test, an undefined opcode or an edge with `issue` low.

Decode errors need no clock to be seen. A wrong choice of adder mode, logic function or write-enable appears on `result` and `writeEn` within the same cycle as the opcode change.

The sweeps pair every first operand with source values chosen to reach:
- all eight bit indices;
- both nibble borrow directions;
- both signed overflow directions.

A stuck or mis-steered flag therefore diverges within one issued operation.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND  = 4'd0,
    OP_OR   = 4'd1,
    OP_XOR  = 4'd2,
    OP_NOT  = 4'd3,
    OP_ADD  = 4'd4,
    OP_SUB  = 4'd5,
    OP_CMP  = 4'd6,
    OP_TEST = 4'd7,
    OP_BIT  = 4'd8
  } aluOpE;

  typedef enum logic [2:0] {
    LG_AND  = 3'd0,
    LG_OR   = 3'd1,
    LG_XOR  = 3'd2,
    LG_NOT  = 3'd3,
    LG_PASS = 3'd4,
    LG_ZERO = 3'd5
  } logicSelE;

  typedef struct packed {
    logic     useAdder;
    logic     subtract;
    logicSelE logicSel;
    logic     flagsArith;
    logic     flagsLogic;
    logic     flagsBit;
    logic     writeBack;
  } aluStrobeT;

  typedef struct packed {
    logic zero;
    logic carry;
    logic sign;
    logic ovf;
    logic parity;
    logic aux;
  } aluFlagsT;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import byte_alu_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic [OPW-1:0] opCode,
  output aluStrobeT      strobe
);

  always_comb begin
    strobe          = '0;
    strobe.logicSel = LG_ZERO;
    case (opCode)
      OP_AND: begin
        strobe.logicSel   = LG_AND;
        strobe.flagsLogic = 1'b1;
        strobe.writeBack  = 1'b1;
      end
      OP_OR: begin
        strobe.logicSel   = LG_OR;
        strobe.flagsLogic = 1'b1;
        strobe.writeBack  = 1'b1;
      end
      OP_XOR: begin
        strobe.logicSel   = LG_XOR;
        strobe.flagsLogic = 1'b1;
        strobe.writeBack  = 1'b1;
      end
      OP_NOT: begin
        strobe.logicSel  = LG_NOT;
        strobe.writeBack = 1'b1;
      end
      OP_ADD: begin
        strobe.useAdder   = 1'b1;
        strobe.flagsArith = 1'b1;
        strobe.writeBack  = 1'b1;
      end
      OP_SUB: begin
        strobe.useAdder   = 1'b1;
        strobe.subtract   = 1'b1;
        strobe.flagsArith = 1'b1;
        strobe.writeBack  = 1'b1;
      end
      OP_CMP: begin
        strobe.useAdder   = 1'b1;
        strobe.subtract   = 1'b1;
        strobe.flagsArith = 1'b1;
      end
      OP_TEST: begin
        strobe.logicSel   = LG_AND;
        strobe.flagsLogic = 1'b1;
      end
      OP_BIT: begin
        strobe.logicSel = LG_PASS;
        strobe.flagsBit = 1'b1;
      end
      default: strobe.logicSel = LG_ZERO;
    endcase
  end

  // R10, R11: at most one flag-update class is selected per opcode
  always_comb begin
    update_class_chk: assert ($onehot0({strobe.flagsArith, strobe.flagsLogic, strobe.flagsBit}));
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  aluStrobeT        strobe,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] result,
  output logic             writeEn,
  output aluFlagsT         flagsQ
);

  localparam int IDXW = $clog2(WIDTH);
  localparam int PARW = (WIDTH < 8) ? WIDTH : 8;
  localparam int NIB  = 4;

  logic [WIDTH-1:0] operandB;
  logic [WIDTH:0]   sumFull;
  logic             carryOut;
  logic             carryIntoTop;
  logic             nibbleCarry;
  logic [WIDTH-1:0] logicOut;
  logic [IDXW-1:0]  bitIdx;
  logic             bitVal;
  aluFlagsT         nextFlags;

  // Subtraction as A + ~B + 1; the carry into each bit is recovered from the sum
  assign operandB     = strobe.subtract ? ~srcB : srcB;
  assign sumFull      = {1'b0, srcA} + {1'b0, operandB} + {{WIDTH{1'b0}}, strobe.subtract};
  assign carryOut     = sumFull[WIDTH];
  assign carryIntoTop = srcA[WIDTH-1] ^ operandB[WIDTH-1] ^ sumFull[WIDTH-1];
  assign nibbleCarry  = srcA[NIB] ^ operandB[NIB] ^ sumFull[NIB];

  always_comb begin
    case (strobe.logicSel)
      LG_AND:  logicOut = srcA & srcB;
      LG_OR:   logicOut = srcA | srcB;
      LG_XOR:  logicOut = srcA ^ srcB;
      LG_NOT:  logicOut = ~srcA;
      LG_PASS: logicOut = srcA;
      default: logicOut = '0;
    endcase
  end

  assign result  = strobe.useAdder ? sumFull[WIDTH-1:0] : logicOut;
  assign writeEn = strobe.writeBack;

  assign bitIdx = srcB[IDXW-1:0];
  assign bitVal = srcA[bitIdx];

  always_comb begin
    nextFlags = flagsQ;
    if (strobe.flagsArith || strobe.flagsLogic) begin
      nextFlags.zero   = (result == '0);
      nextFlags.sign   = result[WIDTH-1];
      nextFlags.parity = ~^result[PARW-1:0];
    end
    if (strobe.flagsArith) begin
      nextFlags.carry = carryOut ^ strobe.subtract;
      nextFlags.ovf   = carryOut ^ carryIntoTop;
      nextFlags.aux   = nibbleCarry ^ strobe.subtract;
    end else if (strobe.flagsLogic) begin
      nextFlags.carry = 1'b0;
      nextFlags.ovf   = 1'b0;
      nextFlags.aux   = 1'b0;
    end else if (strobe.flagsBit) begin
      nextFlags.carry = bitVal;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)      flagsQ <= '0;
    else if (issue) flagsQ <= nextFlags;
  end

  // R5
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue && (strobe.flagsArith || strobe.flagsLogic) |=> flagsQ.zero == ($past(result) == '0));

  // R5
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue && (strobe.flagsArith || strobe.flagsLogic) |=> flagsQ.sign == $past(result[WIDTH-1]));

  // R5
  parity_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue && (strobe.flagsArith || strobe.flagsLogic)
      |=> flagsQ.parity == ($countones($past(result[PARW-1:0])) % 2 == 0));

  // R2
  logic_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue && strobe.flagsLogic |=> !flagsQ.carry && !flagsQ.ovf && !flagsQ.aux);

  // R8
  bit_test_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue && strobe.flagsBit |=> flagsQ.carry == $past(srcA[srcB[IDXW-1:0]])
      && flagsQ.zero == $past(flagsQ.zero) && flagsQ.sign == $past(flagsQ.sign)
      && flagsQ.ovf == $past(flagsQ.ovf) && flagsQ.parity == $past(flagsQ.parity)
      && flagsQ.aux == $past(flagsQ.aux));

  // R10
  hold_flags_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issue |=> $stable(flagsQ));

  // R9, R11
  no_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    issue && !strobe.flagsArith && !strobe.flagsLogic && !strobe.flagsBit |=> $stable(flagsQ));

endmodule

// File: rtl/byte_alu.sv
module byte_alu
  import byte_alu_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int OPW   = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issue,
  input  logic [OPW-1:0]   opCode,
  input  logic [WIDTH-1:0] srcA,
  input  logic [WIDTH-1:0] srcB,
  output logic [WIDTH-1:0] result,
  output logic             writeEn,
  output logic             flagZero,
  output logic             flagCarry,
  output logic             flagSign,
  output logic             flagOvf,
  output logic             flagParity,
  output logic             flagAux
);

  aluStrobeT strobe;
  aluFlagsT  flagsQ;

  alu_ctrl #(.OPW(OPW)) u_ctrl (
    .opCode (opCode),
    .strobe (strobe)
  );

  alu_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk     (clk),
    .rstN    (rstN),
    .issue   (issue),
    .strobe  (strobe),
    .srcA    (srcA),
    .srcB    (srcB),
    .result  (result),
    .writeEn (writeEn),
    .flagsQ  (flagsQ)
  );

  assign flagZero   = flagsQ.zero;
  assign flagCarry  = flagsQ.carry;
  assign flagSign   = flagsQ.sign;
  assign flagOvf    = flagsQ.ovf;
  assign flagParity = flagsQ.parity;
  assign flagAux    = flagsQ.aux;

endmodule

// File: tb/byte_alu_bench.sv
module byte_alu_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic       issue;
  logic [3:0] opCode;
  logic [7:0] srcA;
  logic [7:0] srcB;
  logic [7:0] result;
  logic       writeEn;
  logic       flagZero, flagCarry, flagSign, flagOvf, flagParity, flagAux;

  always #5 clk = ~clk;

  byte_alu u_byte_alu (
    .clk        (clk),
    .rstN       (rstN),
    .issue      (issue),
    .opCode     (opCode),
    .srcA       (srcA),
    .srcB       (srcB),
    .result     (result),
    .writeEn    (writeEn),
    .flagZero   (flagZero),
    .flagCarry  (flagCarry),
    .flagSign   (flagSign),
    .flagOvf    (flagOvf),
    .flagParity (flagParity),
    .flagAux    (flagAux)
  );

  int nRun = 0;
  int nFail = 0;
  bit done = 0;

  // model flags, order {Z,C,S,O,P,A}
  logic [5:0] mFlags;
  logic [7:0] eRes;
  logic       eWe;
  logic [5:0] eFlags;
  string      reqTag;

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s op=%0d a=%02h b=%02h actual=%0h expected=%0h",
               req, what, opCode, srcA, srcB, act, exp);
    end
  endtask

  task automatic model(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b);
    int ia, ib, t;
    logic z, c, s, o, p, x;
    ia = int'(a);
    ib = int'(b);
    {z, c, s, o, p, x} = mFlags;
    eRes = 8'h00;
    eWe = 1'b0;
    case (op)
      4'd0, 4'd1, 4'd2, 4'd7: begin
        eRes = (op == 4'd1) ? (a | b) : (op == 4'd2) ? (a ^ b) : (a & b);
        eWe = (op != 4'd7);
        c = 1'b0; o = 1'b0; x = 1'b0;
        reqTag = (op == 4'd7) ? "R7/R5" : "R2/R5";
      end
      4'd3: begin
        eRes = ~a;
        eWe = 1'b1;
        reqTag = "R9";
      end
      4'd4: begin
        t = ia + ib;
        eRes = t[7:0];
        eWe = 1'b1;
        c = (t > 255);
        x = ((ia % 16) + (ib % 16)) > 15;
        o = (a[7] == b[7]) && (eRes[7] != a[7]);
        reqTag = "R3/R5";
      end
      4'd5, 4'd6: begin
        t = ia - ib;
        eRes = t[7:0];
        eWe = (op == 4'd5);
        c = (ia < ib);
        x = (ia % 16) < (ib % 16);
        o = (a[7] != b[7]) && (eRes[7] != a[7]);
        reqTag = (op == 4'd6) ? "R6/R5" : "R4/R5";
      end
      4'd8: begin
        eRes = a;
        c = a[b[2:0]];
        reqTag = "R8";
      end
      default: reqTag = "R11";
    endcase
    if (op <= 4'd7 && op != 4'd3) begin
      z = (eRes == 8'h00);
      s = eRes[7];
      p = ($countones(eRes) % 2) == 0;
    end
    eFlags = {z, c, s, o, p, x};
  endtask

  task automatic runOp(input logic [3:0] op, input logic [7:0] a, input logic [7:0] b,
                       input logic doIssue);
    @(negedge clk);
    opCode = op;
    srcA = a;
    srcB = b;
    issue = doIssue;
    model(op, a, b);
    #1;
    check(reqTag, "result", 32'(result), 32'(eRes));
    check(reqTag, "writeEn", 32'(writeEn), 32'(eWe));
    @(posedge clk);
    #1;
    if (doIssue) mFlags = eFlags;
    else reqTag = "R10";
    check(reqTag, "flags", 32'({flagZero, flagCarry, flagSign, flagOvf, flagParity, flagAux}),
          32'(mFlags));
  endtask

  logic [7:0] bSet [16] = '{8'h00, 8'h01, 8'h02, 8'h03, 8'h07, 8'h08, 8'h0F, 8'h10,
                            8'h7F, 8'h80, 8'h81, 8'hF0, 8'hFE, 8'hFF, 8'h0C, 8'h45};

  initial begin
    rstN = 1'b0;
    issue = 1'b1;
    opCode = 4'd4;
    srcA = 8'hFF;
    srcB = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    mFlags = 6'b0;
    // R1: reset state
    check("R1", "flags", 32'({flagZero, flagCarry, flagSign, flagOvf, flagParity, flagAux}), 0);
    @(negedge clk);
    rstN = 1'b1;
    issue = 1'b0;

    // R6 explicit compare corners
    runOp(4'd6, 8'd4, 8'd5, 1'b1);
    check("R6", "below CF/ZF", 32'({flagCarry, flagZero}), 32'b10);
    runOp(4'd6, 8'd5, 8'd5, 1'b1);
    check("R6", "equal CF/ZF", 32'({flagCarry, flagZero}), 32'b01);
    runOp(4'd6, 8'd6, 8'd5, 1'b1);
    check("R6", "above CF/ZF", 32'({flagCarry, flagZero}), 32'b00);

    // main sweep over all defined opcodes
    for (int op = 0; op <= 8; op++)
      for (int a = 0; a < 256; a++)
        for (int k = 0; k < 16; k++)
          runOp(4'(op), 8'(a), bSet[k], 1'b1);

    // R10: no issue, flags hold
    for (int k = 0; k < 16; k++) runOp(4'd5, 8'h00, bSet[k], 1'b0);
    for (int k = 0; k < 16; k++) runOp(4'd0, 8'(k * 17), 8'h00, 1'b0);

    // R11: undefined opcodes
    for (int op = 9; op < 16; op++)
      for (int k = 0; k < 16; k++) runOp(4'(op), 8'hA5, bSet[k], 1'b1);

    // R9: NOT after a flag-setting operation
    runOp(4'd5, 8'h00, 8'h01, 1'b1);
    runOp(4'd3, 8'h5A, 8'h00, 1'b1);

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    #3000000;
    if (!done) begin
      done = 1;
      nRun++;
      nFail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule